// File: doc/BRIEF.md
# Switch Port Status Poller

This block keeps a live copy of link state, duplex mode and line rate for a single switch port. It never talks to the management bus directly. It drives a paged register read interface, which carries a page number, an offset and an access width (16 or 32 bits). The read engine behind that interface answers each read with a one-cycle completion pulse, an error flag and the returned data.

Each rising of the external tick input starts a poll round. A round is three reads, always in the same order:

1. The link summary.
2. The duplex summary.
3. The speed summary.

The bits for the monitored port are held in staging registers until the round ends. If all three reads succeed, they move to the outputs in a single cycle and a success pulse is raised. If any read reports an error, the round ends at once with a failure pulse and the previous outputs stay in place.

The monitored port is a parameter. Its default is index 8, the port that faces the host CPU.

Top module: `port_status_poller`

## Requirements
- R1: While reset is held and in the first cycle after it, rdReq, linkUp, fullDuplex, speedOneHot, speedUnknown, pollOk and pollFail are all 0.
- R2: A pollTick seen while idle makes rdReq high in the next cycle. Every request carries page 0x01.
- R3: The reads of a round are issued in a fixed order:
  - offset 0x00 with rdWide=0 (16 bit),
  - then offset 0x08 with rdWide=0,
  - then offset 0x04 with rdWide=1 (32 bit).
  Each later request is presented in the cycle after the rdDone of the one before it.
- R4: linkUp reports bit PORT_IDX of the link word. On 16-bit reads, bits 31:16 of rdData are ignored.
- R5: fullDuplex reports bit PORT_IDX of the duplex word: 1 means full duplex, 0 means half duplex.
- R6: The speed code is bits [2*PORT_IDX+1 : 2*PORT_IDX] of the speed word. Code 0 sets speedOneHot=3'b001 (10 Mb/s), code 1 sets 3'b010 (100 Mb/s) and code 2 sets 3'b100 (1000 Mb/s). speedOneHot never has more than one bit set.
- R7: Speed code 3 sets speedUnknown=1 and speedOneHot=3'b000. Codes 0 to 2 clear speedUnknown.
- R8: When the speed read completes without error, the outputs take the round's values in the following cycle. pollOk pulses high for exactly that one cycle. The outputs change at no other time.
- R9: If any read completes with rdErr=1:
  - pollFail pulses for one cycle in the following cycle,
  - rdReq drops in that same cycle,
  - pollOk stays low,
  - all status outputs keep their previous values.
- R10: A pollTick that arrives while a round is active is ignored. The round goes on unchanged, and no new round starts after it.
- R11: An rdDone that arrives while no request is outstanding has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pollTick | input | 1 | Starts a round when the block is idle |
| rdReq | output | 1 | Read request, held until rdDone |
| rdPage | output | 8 | Page of the requested register |
| rdOffset | output | 8 | Offset of the requested register |
| rdWide | output | 1 | 1 = 32-bit read, 0 = 16-bit read |
| rdDone | input | 1 | One-cycle completion of the current read |
| rdErr | input | 1 | Qualifies rdDone: the read failed |
| rdData | input | 32 | Read data, valid with rdDone |
| linkUp | output | 1 | Link of the monitored port is up |
| fullDuplex | output | 1 | Monitored port runs full duplex |
| speedOneHot | output | 3 | bit0 = 10, bit1 = 100, bit2 = 1000 Mb/s |
| speedUnknown | output | 1 | Reserved speed code was read |
| pollOk | output | 1 | One-cycle pulse: round succeeded, outputs updated |
| pollFail | output | 1 | One-cycle pulse: round aborted on a read error |

## Verification
The assertions check the following on every cycle:
- every request carries the status page,
- a fresh request always begins at the link offset,
- a 32-bit request only ever targets the speed offset,
- success and failure never coincide,
- rdReq is dropped when a round fails,
- status outputs move only together with pollOk,
- the speed outputs never show two rates at once, nor a rate alongside the unknown flag.

Some behaviour only the bench scenarios can show:
- that the correct bit or field of each word is picked out of noisy neighbouring bits,
- that each of the four speed codes decodes correctly,
- that an error at each of the three stages leaves earlier results untouched,
- that ticks arriving mid-round, and stray completions, change nothing.

// File: rtl/psp_pkg.sv
package psp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LINK = 2'd1,
    ST_DUP  = 2'd2,
    ST_SPD  = 2'd3
  } pollState_t;

  // strobes from control to datapath, already qualified by a good completion
  typedef struct packed {
    logic capLink;
    logic capDuplex;
    logic commit;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    SPD_10   = 2'd0,
    SPD_100  = 2'd1,
    SPD_1000 = 2'd2,
    SPD_RSVD = 2'd3
  } speedCode_t;

  localparam int RATE_CNT = 3;

endpackage

// File: rtl/psp_ctrl.sv
module psp_ctrl
  import psp_pkg::*;
#(
  parameter int          PAGE_W    = 8,
  parameter int          OFF_W     = 8,
  parameter logic [7:0]  STAT_PAGE = 8'h01,
  parameter logic [7:0]  LINK_OFF  = 8'h00,
  parameter logic [7:0]  DUP_OFF   = 8'h08,
  parameter logic [7:0]  SPD_OFF   = 8'h04
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pollTick,
  input  logic              rdDone,
  input  logic              rdErr,
  output logic              rdReq,
  output logic [PAGE_W-1:0] rdPage,
  output logic [OFF_W-1:0]  rdOffset,
  output logic              rdWide,
  output dpStrobe_t         strb,
  output logic              pollOk,
  output logic              pollFail
);

  pollState_t state;
  pollState_t stateNext;
  logic       goodDone;
  logic       badDone;

  assign goodDone = rdReq && rdDone && !rdErr;
  assign badDone  = rdReq && rdDone && rdErr;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (pollTick) stateNext = ST_LINK;
      ST_LINK: if (badDone) stateNext = ST_IDLE;
               else if (goodDone) stateNext = ST_DUP;
      ST_DUP:  if (badDone) stateNext = ST_IDLE;
               else if (goodDone) stateNext = ST_SPD;
      ST_SPD:  if (rdDone) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pollOk   <= 1'b0;
      pollFail <= 1'b0;
    end else begin
      state    <= stateNext;
      pollOk   <= goodDone && (state == ST_SPD);
      pollFail <= badDone;
    end
  end

  always_comb begin
    rdReq  = (state != ST_IDLE);
    rdPage = PAGE_W'(STAT_PAGE);
    rdWide = (state == ST_SPD);
    unique case (state)
      ST_DUP:  rdOffset = OFF_W'(DUP_OFF);
      ST_SPD:  rdOffset = OFF_W'(SPD_OFF);
      default: rdOffset = OFF_W'(LINK_OFF);
    endcase
    strb.capLink   = goodDone && (state == ST_LINK);
    strb.capDuplex = goodDone && (state == ST_DUP);
    strb.commit    = goodDone && (state == ST_SPD);
  end

  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> rdPage == PAGE_W'(STAT_PAGE)); // R2

  AST_ROUND_STARTS_LINK: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !$past(rdReq)) |-> rdOffset == OFF_W'(LINK_OFF)); // R3

  AST_WIDE_ONLY_SPEED: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdWide) |-> rdOffset == OFF_W'(SPD_OFF)); // R3

  AST_OK_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(pollOk && pollFail)); // R9

  AST_FAIL_DROPS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    pollFail |-> !rdReq); // R9

endmodule

// File: rtl/psp_datapath.sv
module psp_datapath
  import psp_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int HALF_W   = 16,
  parameter int PORT_IDX = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strb,
  input  logic [DATA_W-1:0]   rdData,
  output logic                linkUp,
  output logic                fullDuplex,
  output logic [RATE_CNT-1:0] speedOneHot,
  output logic                speedUnknown
);

  localparam int SPD_LSB = 2 * PORT_IDX;

  logic [HALF_W-1:0]   halfWord;
  logic                linkStage;
  logic                dupStage;
  speedCode_t          spdCode;
  logic [RATE_CNT-1:0] rateDecoded;

  // 16-bit reads only look at the low half of the data bus
  assign halfWord = rdData[HALF_W-1:0];
  assign spdCode  = speedCode_t'(rdData[SPD_LSB +: 2]);

  for (genvar c = 0; c < RATE_CNT; c++) begin : g_rate
    assign rateDecoded[c] = (spdCode == speedCode_t'(c));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkStage <= 1'b0;
      dupStage  <= 1'b0;
    end else begin
      if (strb.capLink)   linkStage <= halfWord[PORT_IDX];
      if (strb.capDuplex) dupStage  <= halfWord[PORT_IDX];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkUp       <= 1'b0;
      fullDuplex   <= 1'b0;
      speedOneHot  <= '0;
      speedUnknown <= 1'b0;
    end else if (strb.commit) begin
      linkUp       <= linkStage;
      fullDuplex   <= dupStage;
      speedOneHot  <= rateDecoded;
      speedUnknown <= (spdCode == SPD_RSVD);
    end
  end

  AST_RATE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(speedOneHot)); // R6

  AST_UNK_NO_RATE: assert property (@(posedge clk) disable iff (!rstN)
    speedUnknown |-> speedOneHot == '0); // R7

endmodule

// File: rtl/port_status_poller.sv
module port_status_poller
  import psp_pkg::*;
#(
  parameter int PORT_IDX = 8,
  parameter int DATA_W   = 32,
  parameter int PAGE_W   = 8,
  parameter int OFF_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pollTick,
  output logic              rdReq,
  output logic [PAGE_W-1:0] rdPage,
  output logic [OFF_W-1:0]  rdOffset,
  output logic              rdWide,
  input  logic              rdDone,
  input  logic              rdErr,
  input  logic [DATA_W-1:0] rdData,
  output logic              linkUp,
  output logic              fullDuplex,
  output logic [2:0]        speedOneHot,
  output logic              speedUnknown,
  output logic              pollOk,
  output logic              pollFail
);

  dpStrobe_t strb;

  psp_ctrl #(
    .PAGE_W(PAGE_W),
    .OFF_W (OFF_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .pollTick(pollTick),
    .rdDone  (rdDone),
    .rdErr   (rdErr),
    .rdReq   (rdReq),
    .rdPage  (rdPage),
    .rdOffset(rdOffset),
    .rdWide  (rdWide),
    .strb    (strb),
    .pollOk  (pollOk),
    .pollFail(pollFail)
  );

  psp_datapath #(
    .DATA_W  (DATA_W),
    .PORT_IDX(PORT_IDX)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .rdData      (rdData),
    .linkUp      (linkUp),
    .fullDuplex  (fullDuplex),
    .speedOneHot (speedOneHot),
    .speedUnknown(speedUnknown)
  );

  AST_OUT_MOVE_WITH_OK: assert property (@(posedge clk) disable iff (!rstN)
    ({linkUp, fullDuplex, speedOneHot, speedUnknown} !=
     $past({linkUp, fullDuplex, speedOneHot, speedUnknown})) |-> pollOk); // R8

  AST_OK_IS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    pollOk |=> !pollOk); // R8

endmodule

// File: tb/port_status_poller_bench.sv
module port_status_poller_bench;

  localparam int PORT = 8;

  logic        clk = 1'b0;
  logic        rstN;
  logic        pollTick;
  logic        rdReq;
  logic [7:0]  rdPage;
  logic [7:0]  rdOffset;
  logic        rdWide;
  logic        rdDone;
  logic        rdErr;
  logic [31:0] rdData;
  logic        linkUp;
  logic        fullDuplex;
  logic [2:0]  speedOneHot;
  logic        speedUnknown;
  logic        pollOk;
  logic        pollFail;

  int total = 0;
  int bad   = 0;

  logic       expLink = 1'b0;
  logic       expDup  = 1'b0;
  logic [2:0] expRate = 3'b000;
  logic       expUnk  = 1'b0;

  always #2 clk = ~clk;

  port_status_poller u_port_status_poller (
    .clk(clk), .rstN(rstN), .pollTick(pollTick),
    .rdReq(rdReq), .rdPage(rdPage), .rdOffset(rdOffset), .rdWide(rdWide),
    .rdDone(rdDone), .rdErr(rdErr), .rdData(rdData),
    .linkUp(linkUp), .fullDuplex(fullDuplex), .speedOneHot(speedOneHot),
    .speedUnknown(speedUnknown), .pollOk(pollOk), .pollFail(pollFail)
  );

  function automatic logic [2:0] rateOf(input logic [31:0] w);
    logic [1:0] code = w[2*PORT +: 2];
    case (code)
      2'd0:    return 3'b001;
      2'd1:    return 3'b010;
      2'd2:    return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [7:0] offOf(input int s);
    return (s == 0) ? 8'h00 : (s == 1) ? 8'h08 : 8'h04;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkOutputs(input string tag);
    chk({tag, " linkUp"}, 32'(linkUp), 32'(expLink));
    chk({tag, " fullDuplex"}, 32'(fullDuplex), 32'(expDup));
    chk({tag, " speedOneHot"}, 32'(speedOneHot), 32'(expRate));
    chk({tag, " speedUnknown"}, 32'(speedUnknown), 32'(expUnk));
  endtask

  // one poll round; errStage 0..2 injects an error, 3 means none
  task automatic runRound(input logic [31:0] wLink, input logic [31:0] wDup,
                          input logic [31:0] wSpd, input int errStage,
                          input int lat, input bit tickMid);
    logic [31:0] words [3];
    words[0] = wLink; words[1] = wDup; words[2] = wSpd;
    pollTick = 1'b1;
    @(negedge clk);
    pollTick = 1'b0;
    for (int s = 0; s < 3; s++) begin
      chk("R2 rdReq", 32'(rdReq), 32'd1);
      chk("R2 rdPage", 32'(rdPage), 32'h01);
      chk("R3 rdOffset", 32'(rdOffset), 32'(offOf(s)));
      chk("R3 rdWide", 32'(rdWide), (s == 2) ? 32'd1 : 32'd0);
      for (int k = 0; k < lat; k++) begin
        if (tickMid && k == 0) pollTick = 1'b1; // R10
        @(negedge clk);
        pollTick = 1'b0;
      end
      rdDone = 1'b1;
      rdErr  = (s == errStage);
      rdData = words[s];
      if (tickMid && s == 1) pollTick = 1'b1; // R10
      @(negedge clk);
      rdDone = 1'b0; rdErr = 1'b0; rdData = $urandom; pollTick = 1'b0;
      if (s == errStage) begin
        chk("R9 pollFail", 32'(pollFail), 32'd1);
        chk("R9 pollOk low", 32'(pollOk), 32'd0);
        chk("R9 rdReq dropped", 32'(rdReq), 32'd0);
        chkOutputs("R9 hold");
        @(negedge clk);
        chk("R10 no restart after fail", 32'(rdReq), 32'd0);
        return;
      end
    end
    expLink = wLink[PORT];
    expDup  = wDup[PORT];
    expRate = rateOf(wSpd);
    expUnk  = (wSpd[2*PORT +: 2] == 2'd3);
    chk("R8 pollOk", 32'(pollOk), 32'd1);
    chk("R8 pollFail low", 32'(pollFail), 32'd0);
    chkOutputs("R4 R5 R6 R7 update");
    @(negedge clk);
    chk("R8 pollOk one cycle", 32'(pollOk), 32'd0);
    chk("R10 no extra round", 32'(rdReq), 32'd0);
    chkOutputs("R8 hold");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    int unsigned seed;
    seed = $urandom(32'd20240611);
    rstN = 1'b0; pollTick = 1'b0; rdDone = 1'b0; rdErr = 1'b0; rdData = '0;
    repeat (3) @(negedge clk);
    chk("R1 rdReq in reset", 32'(rdReq), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 rdReq", 32'(rdReq), 32'd0);
    chk("R1 pollOk", 32'(pollOk), 32'd0);
    chk("R1 pollFail", 32'(pollFail), 32'd0);
    chkOutputs("R1 reset");

    // R4: link bit clear, upper half noisy and bit 24 set; R6 code 0
    runRound(32'hFFFF_FEFF, 32'h0000_0100, 32'hFFFC_FFFF, 3, 1, 1'b0);
    // R4/R5/R6: link up, half duplex, code 1
    runRound(32'h0000_0100, 32'hFFFF_FEFF, 32'h0001_0000, 3, 0, 1'b0);
    // R6: code 2, full duplex
    runRound(32'h0000_0100, 32'h0000_0100, 32'h0002_0000, 3, 2, 1'b1);
    // R7: reserved code 3
    runRound(32'h0000_0100, 32'h0000_0100, 32'h0003_0000, 3, 0, 1'b0);
    // R9: error at each stage with words that would flip everything
    runRound(32'h0, 32'h0, 32'h0, 0, 1, 1'b0);
    runRound(32'h0, 32'h0, 32'h0, 1, 0, 1'b1);
    runRound(32'h0, 32'h0, 32'h0, 2, 2, 1'b0);
    // R11: stray completion while idle
    rdDone = 1'b1; rdData = 32'h0; @(negedge clk); rdDone = 1'b0;
    @(negedge clk);
    chk("R11 stray pollOk", 32'(pollOk), 32'd0);
    chk("R11 stray rdReq", 32'(rdReq), 32'd0);
    chkOutputs("R11 stray");

    for (int i = 0; i < 60; i++) begin
      int es;
      es = ($urandom % 5 == 0) ? int'($urandom % 3) : 3;
      runRound($urandom, $urandom, $urandom, es, int'($urandom % 4), 1'($urandom));
      repeat ($urandom % 3) @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule